// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block carries out the three vector configuration instructions of a vector-capable core and owns the architectural element-type register (a 64-bit word) and the active vector length. Each cycle it may be offered one instruction word together with the two scalar source operands already read from the register file. When the word carries the configuration opcode, the block works out which of the three forms it is. It takes the requested element type and the application vector length (AVL) from the right place, checks the element type for legality, and derives the largest vector length that the machine register group can hold (VLMAX). It then picks the new vector length.

One clock after it accepts a request, the new state is visible on its outputs. A writeback strobe presents the new vector length as the destination register value, and the same strobe tells the vector unit to zero its start index. Any word that is not a configuration instruction leaves the block untouched.

Top module: `vcfg_unit`

## Requirements
- R1: While reset is high and after reset, the element-type word reads 0x8000_0000_0000_0000 (only bit 63, the illegal flag, set), the vector length reads 0, and the writeback strobe is low.
- R2: A request is accepted only when `req_valid` is high, instruction bits 6:0 equal 1010111 and bits 14:12 equal 111. Any other request changes neither the element type nor the vector length, and raises no strobe.
- R3: An accepted request updates the element type and vector length at the next clock edge. On that same edge `rsp_valid` and `vstart_clr` go high for exactly one cycle, and `rsp_wdata` carries the new vector length zero-extended.
- R4: The form is chosen by instruction bits 31:30. With bit 31 clear, the element type is bits 30:20 zero-extended and the AVL is `rs1_val`. With 11, the element type is bits 29:20 zero-extended, the AVL is the 5-bit value in bits 19:15, and the rs1 field always counts as nonzero. With 10, the AVL is `rs1_val` and the element type is `rs2_val`. The rd field is bits 11:7 and the rs1 field is bits 19:15.
- R5: Element-type fields are: bits 2:0 the multiplier code (000/001/010/011 = 1/2/4/8, 101/110/111 = 1/8, 1/4, 1/2); bits 5:3 the element-width code (000..011 = 8/16/32/64 bits); bit 6 tail-agnostic; bit 7 mask-agnostic; bit 63 the illegal flag.
- R6: A requested element type is illegal if the multiplier code is 100, the width code is 1xx, the element width exceeds ELEN times min(multiplier, 1), or any of bits 63:8 is set. In that case the stored word becomes 0x8000_0000_0000_0000 and the new vector length is 0.
- R7: When the requested element type equals the stored one, the stored word is kept as it is.
- R8: For a legal element type, VLMAX = VLEN × multiplier / element width, where VLEN = 8 × VLENB.
- R9: The new length depends on the register fields. With rd and rs1 both zero, it is the old length clamped to VLMAX. With rd nonzero and rs1 zero, it is VLMAX. With rs1 nonzero (or in the 5-bit-immediate form), it is the AVL clamped to VLMAX.
- R10: The new vector length never exceeds VLMAX. An AVL at or below VLMAX passes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction word offered this cycle |
| req_insn | input | 32 | Instruction word |
| rs1_val | input | XLEN | Scalar value read through the rs1 field |
| rs2_val | input | XLEN | Scalar value read through the rs2 field |
| rsp_valid | output | 1 | Destination writeback strobe, one cycle after acceptance |
| rsp_wdata | output | XLEN | New vector length, zero-extended |
| vstart_clr | output | 1 | Zero the vector start index |
| vtype_o | output | 64 | Stored element-type word |
| vl_o | output | clog2(VLEN)+1 | Stored vector length |

## Verification
The bench builds the block with its defaults: VLENB of 32 bytes (VLEN 256 bits), ELEN of 64 and XLEN of 64. With these values VLMAX runs from 4 (64-bit elements at multiplier 1, or 8-bit elements at 1/8) up to 256 (8-bit elements at multiplier 8). So a register AVL above 256 reaches the clamp. At the smallest fractional multipliers the width rule admits only the narrowest elements, so both sides of the fractional legality edge (16-bit at 1/4 legal, 32-bit at 1/4 not) can be reached. The vector table chains requests so that each one starts from the state the previous one left, which exercises the keep-old-length and same-element-type paths.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

    localparam logic [6:0]  OPC_VECTOR = 7'b1010111;
    localparam logic [2:0]  F3_CONFIG  = 3'b111;
    localparam logic [63:0] VTYPE_BAD  = 64'h8000_0000_0000_0000;

    typedef enum logic [1:0] {
        FORM_IMM_TYPE = 2'd0,
        FORM_IMM_AVL  = 2'd1,
        FORM_REG_REG  = 2'd2
    } cfg_form_e;

    typedef struct packed {
        cfg_form_e   form;
        logic [4:0]  rd;
        logic        rs1_nz;
        logic [63:0] vtype;
    } cfg_req_t;

    // log2 of the register-group multiplier; code 100 is never legal
    function automatic int lmul_log2(input logic [2:0] code);
        case (code)
            3'b000:  return 0;
            3'b001:  return 1;
            3'b010:  return 2;
            3'b011:  return 3;
            3'b101:  return -3;
            3'b110:  return -2;
            3'b111:  return -1;
            default: return 0;
        endcase
    endfunction

    function automatic int sew_log2(input logic [1:0] code);
        return 3 + int'(code);
    endfunction

    function automatic logic vtype_legal(input logic [63:0] v, input int elen_log);
        int lm;
        lm = lmul_log2(v[2:0]);
        if (lm > 0) lm = 0;
        return (v[63:8] == '0) && !v[5] && (v[2:0] != 3'b100)
            && (sew_log2(v[4:3]) <= elen_log + lm);
    endfunction

endpackage

// File: rtl/vcfg_decode.sv
module vcfg_decode
    import vcfg_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            req_valid,
    input  logic [31:0]     req_insn,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    output logic            accept,
    output cfg_req_t        req,
    output logic [XLEN-1:0] avl
);
    logic [4:0] rs1_idx;

    assign rs1_idx = req_insn[19:15];
    assign accept  = req_valid && (req_insn[6:0] == OPC_VECTOR)
                     && (req_insn[14:12] == F3_CONFIG);

    always_comb begin
        req.rd = req_insn[11:7];
        if (!req_insn[31]) begin
            req.form   = FORM_IMM_TYPE;
            req.vtype  = {53'd0, req_insn[30:20]};
            req.rs1_nz = (rs1_idx != 5'd0);
            avl        = rs1_val;
        end else if (req_insn[30]) begin
            req.form   = FORM_IMM_AVL;
            req.vtype  = {54'd0, req_insn[29:20]};
            req.rs1_nz = 1'b1;
            avl        = XLEN'(rs1_idx);
        end else begin
            req.form   = FORM_REG_REG;
            req.vtype  = 64'(rs2_val);
            req.rs1_nz = (rs1_idx != 5'd0);
            avl        = rs1_val;
        end
    end
endmodule

// File: rtl/vcfg_vtype_sel.sv
module vcfg_vtype_sel
    import vcfg_pkg::*;
#(
    parameter int ELEN_LOG = 6
) (
    input  logic [63:0] cur_vtype,
    input  logic [63:0] req_vtype,
    output logic [63:0] new_vtype
);
    logic same;
    logic ok;

    assign same = (req_vtype == cur_vtype);
    assign ok   = vtype_legal(req_vtype, ELEN_LOG);

    always_comb begin
        if (same)    new_vtype = cur_vtype;
        else if (ok) new_vtype = req_vtype;
        else         new_vtype = VTYPE_BAD;
    end
endmodule

// File: rtl/vcfg_vlmax.sv
module vcfg_vlmax
    import vcfg_pkg::*;
#(
    parameter int VLEN_LOG = 8,
    parameter int VL_W     = 9
) (
    input  logic            ill,
    input  logic [5:0]      fields,
    output logic [VL_W-1:0] vlmax
);
    int sh;

    always_comb begin
        sh = VLEN_LOG + lmul_log2(fields[2:0]) - sew_log2(fields[4:3]);
        if (ill || fields[5] || (fields[2:0] == 3'b100) || (sh < 0) || (sh >= VL_W))
            vlmax = '0;
        else
            vlmax = VL_W'(1) << sh;
    end
endmodule

// File: rtl/vcfg_vl_pick.sv
module vcfg_vl_pick #(
    parameter int XLEN = 64,
    parameter int VL_W = 9
) (
    input  logic [VL_W-1:0] vlmax,
    input  logic [VL_W-1:0] cur_vl,
    input  logic [XLEN-1:0] avl,
    input  logic            rd_nz,
    input  logic            rs1_nz,
    output logic [VL_W-1:0] new_vl
);
    logic [XLEN-1:0] vlmax_x;

    assign vlmax_x = XLEN'(vlmax);

    always_comb begin
        if (vlmax == '0)
            new_vl = '0;
        else if (rs1_nz)
            new_vl = (avl > vlmax_x) ? vlmax : VL_W'(avl);
        else if (rd_nz)
            new_vl = vlmax;
        else
            new_vl = (cur_vl > vlmax) ? vlmax : cur_vl;
    end
endmodule

// File: rtl/vcfg_unit.sv
module vcfg_unit
    import vcfg_pkg::*;
#(
    parameter int VLENB = 32,
    parameter int ELEN  = 64,
    parameter int XLEN  = 64
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic [31:0]                   req_insn,
    input  logic [XLEN-1:0]               rs1_val,
    input  logic [XLEN-1:0]               rs2_val,
    output logic                          rsp_valid,
    output logic [XLEN-1:0]               rsp_wdata,
    output logic                          vstart_clr,
    output logic [63:0]                   vtype_o,
    output logic [$clog2(VLENB*8):0]      vl_o
);
    localparam int VLEN     = VLENB * 8;
    localparam int VLEN_LOG = $clog2(VLEN);
    localparam int ELEN_LOG = $clog2(ELEN);
    localparam int VL_W     = VLEN_LOG + 1;

    logic            accept;
    cfg_req_t        req;
    logic [XLEN-1:0] avl;
    logic [63:0]     vtype_q, cand_vtype;
    logic [VL_W-1:0] vl_q, vlmax, new_vl;
    logic            rsp_q;

    vcfg_decode #(.XLEN(XLEN)) u_dec (
        .req_valid(req_valid), .req_insn(req_insn), .rs1_val(rs1_val),
        .rs2_val(rs2_val), .accept(accept), .req(req), .avl(avl)
    );

    vcfg_vtype_sel #(.ELEN_LOG(ELEN_LOG)) u_sel (
        .cur_vtype(vtype_q), .req_vtype(req.vtype), .new_vtype(cand_vtype)
    );

    vcfg_vlmax #(.VLEN_LOG(VLEN_LOG), .VL_W(VL_W)) u_vlmax (
        .ill(cand_vtype[63]), .fields(cand_vtype[5:0]), .vlmax(vlmax)
    );

    vcfg_vl_pick #(.XLEN(XLEN), .VL_W(VL_W)) u_pick (
        .vlmax(vlmax), .cur_vl(vl_q), .avl(avl), .rd_nz(req.rd != 5'd0),
        .rs1_nz(req.rs1_nz), .new_vl(new_vl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vtype_q <= VTYPE_BAD;
            vl_q    <= '0;
            rsp_q   <= 1'b0;
        end else begin
            rsp_q <= accept;
            if (accept) begin
                vtype_q <= cand_vtype;
                vl_q    <= new_vl;
            end
        end
    end

    assign rsp_valid  = rsp_q;
    assign vstart_clr = rsp_q;
    assign rsp_wdata  = XLEN'(vl_q);
    assign vtype_o    = vtype_q;
    assign vl_o       = vl_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (vtype_q == VTYPE_BAD) && (vl_q == '0) && !rsp_q);

    // R2
    ignore_chk: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(vtype_q) && $stable(vl_q) && !rsp_q);

    // R3
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> rsp_q);

    // R6
    illegal_collapse_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_q && vtype_q[63]) |-> (vtype_q[62:0] == '0) && (vl_q == '0));

    // R7
    same_vtype_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (req.vtype == vtype_q)) |=> (vtype_q == $past(vtype_q)));

    // R8
    vlmax_pow2_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !cand_vtype[63]) |-> ($countones(vlmax) == 1));

    // R10
    vl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (vl_q <= $past(vlmax)));
endmodule

// File: tb/sim_vcfg_unit.sv
`timescale 1ns/1ps
module sim_vcfg_unit;
    localparam logic [63:0] BAD = 64'h8000_0000_0000_0000;

    typedef struct packed {
        logic [31:0] insn;
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] vt;
        logic [8:0]  vl;
        logic [7:0]  rq;
    } vec_t;

    function automatic logic [31:0] i_vli(input logic [10:0] z, input logic [4:0] rs1, input logic [4:0] rd);
        return {1'b0, z, rs1, 3'b111, rd, 7'b1010111};
    endfunction
    function automatic logic [31:0] i_ivli(input logic [9:0] z, input logic [4:0] uimm, input logic [4:0] rd);
        return {2'b11, z, uimm, 3'b111, rd, 7'b1010111};
    endfunction
    function automatic logic [31:0] i_vl(input logic [4:0] rs1, input logic [4:0] rd);
        return {2'b10, 5'd0, 5'd7, rs1, 3'b111, rd, 7'b1010111};
    endfunction

    // chained: each entry starts from the state the previous one left
    localparam vec_t VECS [18] = '{
        '{i_vli(11'h010, 5'd2, 5'd1), 64'd10,  64'h1B, 64'h10, 9'd8,   8'd4},  // R4 R10 e32 m1
        '{i_vli(11'h003, 5'd2, 5'd1), 64'd300, 64'd0,  64'h03, 9'd256, 8'd10}, // R10 e8 m8 clamp
        '{i_vli(11'h009, 5'd0, 5'd0), 64'd0,   64'd0,  64'h09, 9'd32,  8'd9},  // R9 keep old, clamp
        '{i_vli(11'h01A, 5'd0, 5'd3), 64'd0,   64'd0,  64'h1A, 9'd16,  8'd9},  // R9 rd only -> VLMAX
        '{i_ivli(10'h0C7, 5'd5, 5'd0), 64'd99, 64'd0,  64'hC7, 9'd5,   8'd4},  // R4 R5 e8 mf2 ta ma
        '{i_ivli(10'h0C7, 5'd0, 5'd4), 64'd99, 64'd0,  64'hC7, 9'd0,   8'd4},  // R4 rs1 counts nonzero
        '{i_vl(5'd6, 5'd5), 64'd3, 64'h1D, BAD, 9'd0, 8'd6},                   // R6 e64 mf8
        '{i_vl(5'd0, 5'd0), 64'd9, 64'h10, 64'h10, 9'd0, 8'd9},                // R9 keep old vl 0
        '{i_vli(11'h010, 5'd1, 5'd1), 64'd7,   64'd0,  64'h10, 9'd7,   8'd10}, // R10 below VLMAX
        '{i_vli(11'h010, 5'd0, 5'd0), 64'd0,   64'd0,  64'h10, 9'd7,   8'd7},  // R7 same vtype
        '{i_vl(5'd1, 5'd1), 64'd5, 64'h110, BAD, 9'd0, 8'd6},                  // R6 reserved bit 8
        '{i_vli(11'h004, 5'd1, 5'd1), 64'd5,   64'd0,  BAD,    9'd0,   8'd6},  // R6 lmul code 100
        '{i_vli(11'h020, 5'd1, 5'd1), 64'd5,   64'd0,  BAD,    9'd0,   8'd6},  // R6 sew code 1xx
        '{i_vl(5'd1, 5'd1), 64'd5, 64'h8000_0000_0000_0010, BAD, 9'd0, 8'd6},  // R6 bit 63 request
        '{i_vli(11'h00E, 5'd0, 5'd2), 64'd0,   64'd0,  64'h0E, 9'd4,   8'd8},  // R8 e16 mf4
        '{i_vli(11'h016, 5'd1, 5'd1), 64'd5,   64'd0,  BAD,    9'd0,   8'd6},  // R6 e32 mf4
        '{i_vli(11'h005, 5'd1, 5'd1), 64'd4,   64'd0,  64'h05, 9'd4,   8'd8},  // R8 e8 mf8, AVL==VLMAX
        '{i_vl(5'd1, 5'd1), 64'd33, 64'h1B, 64'h1B, 9'd32, 8'd8}               // R8 e64 m8 clamp
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_insn;
    logic [63:0] rs1_val, rs2_val;
    logic        rsp_valid, vstart_clr;
    logic [63:0] rsp_wdata, vtype_o;
    logic [8:0]  vl_o;
    int          total = 0;
    int          fails = 0;

    always #2.5 clk = ~clk;

    vcfg_unit u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_insn(req_insn),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .rsp_valid(rsp_valid),
        .rsp_wdata(rsp_wdata), .vstart_clr(vstart_clr), .vtype_o(vtype_o), .vl_o(vl_o)
    );

    task automatic check(input int rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // drive on a falling edge, sample on the following falling edge
    task automatic issue(input logic v, input logic [31:0] insn, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        req_valid = v; req_insn = insn; rs1_val = a; rs2_val = b;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; fails++;
        $display("FAIL R3 watchdog actual=%h expected=%h", 1'b0, 1'b1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_insn = '0; rs1_val = '0; rs2_val = '0;
        repeat (3) @(negedge clk);
        // R1 state held under reset
        check(1, "vtype in reset", vtype_o, BAD);
        check(1, "vl in reset", 64'(vl_o), 64'd0);
        check(1, "strobe in reset", 64'(rsp_valid), 64'd0);
        rst = 1'b0;

        for (int i = 0; i < 18; i++) begin
            issue(1'b1, VECS[i].insn, VECS[i].a, VECS[i].b);
            check(int'(VECS[i].rq), $sformatf("vec %0d vtype", i), vtype_o, VECS[i].vt);
            check(int'(VECS[i].rq), $sformatf("vec %0d vl", i), 64'(vl_o), 64'(VECS[i].vl));
            check(3, $sformatf("vec %0d wdata", i), rsp_wdata, 64'(VECS[i].vl));
            check(3, $sformatf("vec %0d strobes", i), 64'({rsp_valid, vstart_clr}), 64'd3);
        end

        // R3 strobe lasts one cycle
        @(negedge clk);
        check(3, "strobe drops", 64'({rsp_valid, vstart_clr}), 64'd0);

        // R2 wrong funct3 is ignored
        issue(1'b1, {1'b0, 11'h003, 5'd1, 3'b000, 5'd1, 7'b1010111}, 64'd2, 64'd0);
        check(2, "funct3 ignored vtype", vtype_o, 64'h1B);
        check(2, "funct3 ignored vl", 64'(vl_o), 64'd32);
        check(2, "funct3 ignored strobe", 64'(rsp_valid), 64'd0);

        // R2 wrong opcode is ignored
        issue(1'b1, {1'b0, 11'h003, 5'd1, 3'b111, 5'd1, 7'b0010111}, 64'd2, 64'd0);
        check(2, "opcode ignored vl", 64'(vl_o), 64'd32);
        check(2, "opcode ignored strobe", 64'(rsp_valid), 64'd0);

        // R2 valid low is ignored
        issue(1'b0, i_vli(11'h003, 5'd1, 5'd1), 64'd2, 64'd0);
        check(2, "valid low vtype", vtype_o, 64'h1B);
        check(2, "valid low vl", 64'(vl_o), 64'd32);

        // R1 reset mid-run restores the initial state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check(1, "re-reset vtype", vtype_o, BAD);
        check(1, "re-reset vl", 64'(vl_o), 64'd0);

        // R9 keep-old path from reset state with rd=rs1=0
        issue(1'b1, i_vli(11'h018, 5'd0, 5'd0), 64'd0, 64'd0);
        check(9, "keep from zero", 64'(vl_o), 64'd0);
        check(5, "e64 m1 stored", vtype_o, 64'h18);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule